// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block is the programmable digital divider of a frequency synthesizer built around an external 32/33 dual-modulus prescaler. It is clocked by the prescaler output. One division cycle lasts M prescaler-output clocks. During the first A of those clocks the block asks the prescaler to divide by 33. During the remaining M-A clocks it asks for division by 32. The whole cycle therefore spans 32·M + A prescaler input periods. On the last clock of each cycle the block raises a one-clock pulse that goes to the phase comparator.

Software-side settings for A and M arrive through a small write port and are held in shadow registers. The counters pick them up only at a division-cycle boundary, so a cycle in progress is never disturbed. Settings outside the legal range are clamped when they are loaded. This keeps the swallow count below the main count, so the modulus output is always back at divide-by-32 before the pulse.

Top module: `pswallow_div`

## Requirements
- R1: While `rst` is sampled high, `cmp_pulse_o` is 0 and `mod32_o` is 1, and the shadow settings return to `A_INIT` and `M_INIT`. The first rising edge with `rst` low starts a new division cycle with those settings.
- R2: A division cycle lasts exactly M_eff clocks of `psc_clk`. `cmp_pulse_o` is 1 only in the last clock of the cycle and 0 in every other clock.
- R3: In each division cycle, `mod32_o` is 0 (prescaler divides by 33) for the first A_eff clocks and 1 (prescaler divides by 32) for the remaining clocks. An A_eff of 0 keeps `mod32_o` at 1 for the whole cycle.
- R4: A rising edge with `cfg_we` high stores `cfg_data` into the shadow setting selected by `cfg_sel`. A `cfg_sel` of 0 selects A and takes the low `AW` bits. A `cfg_sel` of 1 selects M and takes the low `MW` bits.
- R5: A shadow write changes nothing in the cycle in progress. A write captured before the final edge of a cycle governs the next cycle. A write captured on the final edge of a cycle (the edge that ends the pulse clock) governs the cycle after that.
- R6: A stored M below `MIN_M`, including zero, is used as M_eff = `MIN_M`.
- R7: A stored A not below M_eff is used as A_eff = M_eff - 1. As a result, `mod32_o` is 1 whenever `cmp_pulse_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| psc_clk | input | 1 | Prescaler output clock; all state advances on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Shadow write enable |
| cfg_sel | input | 1 | Shadow select: 0 = swallow count A, 1 = main count M |
| cfg_data | input | max(AW,MW) | Write data |
| mod32_o | output | 1 | Modulus select to prescaler: 1 = divide by 32, 0 = divide by 33 |
| cmp_pulse_o | output | 1 | One-clock pulse per division cycle to the phase comparator |

## Verification
The bench builds the divider with `AW`=4, `MW`=5, `MIN_M`=2, `A_INIT`=3, `M_INIT`=7 and registered outputs. The narrow fields let it reach the full-scale main count of 31 and the largest swallow count of 15 in short runs. They also let a swallow count written above the main count trigger the clamp, and let a write wider than the swallow field show that the upper bits are dropped. The small `MIN_M` lets zero and one as main counts be driven into the clamp, and the short initial settings keep the reset and mid-cycle reset cases brief.

// File: rtl/div_pkg.sv
package div_pkg;

   typedef enum logic {
      SEL_SWALLOW = 1'b0,
      SEL_MAIN    = 1'b1
   } cfg_sel_e;

   function automatic int unsigned width_max(input int unsigned x, input int unsigned y);
      return (x > y) ? x : y;
   endfunction

endpackage

// File: rtl/div_cfg.sv
module div_cfg
   import div_pkg::*;
#(
   parameter int unsigned AW     = 6,
   parameter int unsigned MW     = 8,
   parameter int unsigned DW     = 8,
   parameter int unsigned MIN_M  = 2,
   parameter int unsigned A_INIT = 0,
   parameter int unsigned M_INIT = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  cfg_sel_e      sel,
   input  logic [DW-1:0] data,
   output logic [AW-1:0] a_eff,
   output logic [MW-1:0] m_eff
);
   localparam int unsigned CW = width_max(AW, MW) + 1;

   logic [AW-1:0] a_sh;
   logic [MW-1:0] m_sh;

   always_ff @(posedge clk) begin
      if (rst) begin
         a_sh <= AW'(A_INIT);
         m_sh <= MW'(M_INIT);
      end else if (we) begin
         if (sel == SEL_MAIN) m_sh <= data[MW-1:0];
         else                 a_sh <= data[AW-1:0];
      end
   end

   // clamp to the legal region at the point of use
   always_comb begin
      m_eff = (m_sh < MW'(MIN_M)) ? MW'(MIN_M) : m_sh;
      if (CW'(a_sh) >= CW'(m_eff)) a_eff = AW'(m_eff - 1'b1);
      else                         a_eff = a_sh;
   end

endmodule

// File: rtl/div_swallow_ctr.sv
module div_swallow_ctr #(
   parameter int unsigned AW      = 6,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   output logic          mod32
);
   logic [AW-1:0] cnt, cnt_nxt;

   always_comb begin
      if (rst)             cnt_nxt = '0;
      else if (load)       cnt_nxt = load_val;
      else if (cnt != '0)  cnt_nxt = cnt - 1'b1;
      else                 cnt_nxt = cnt;
   end

   always_ff @(posedge clk) cnt <= cnt_nxt;

   generate
      if (REG_OUT) begin : g_reg
         logic mod_q;
         always_ff @(posedge clk) mod_q <= (cnt_nxt == '0);
         assign mod32 = mod_q;
      end else begin : g_dec
         assign mod32 = (cnt == '0);
      end
   endgenerate

endmodule

// File: rtl/div_main_ctr.sv
module div_main_ctr #(
   parameter int unsigned MW      = 8,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [MW-1:0] load_val,
   output logic          last,
   output logic          pulse
);
   logic [MW-1:0] cnt, cnt_nxt;

   // zero only after reset; one marks the final clock of a cycle
   assign last = (cnt <= MW'(1));

   always_comb begin
      if (rst)       cnt_nxt = '0;
      else if (last) cnt_nxt = load_val;
      else           cnt_nxt = cnt - 1'b1;
   end

   always_ff @(posedge clk) cnt <= cnt_nxt;

   generate
      if (REG_OUT) begin : g_reg
         logic pulse_q;
         always_ff @(posedge clk) pulse_q <= (cnt_nxt == MW'(1));
         assign pulse = pulse_q;
      end else begin : g_dec
         assign pulse = (cnt == MW'(1));
      end
   endgenerate

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
   import div_pkg::*;
#(
   parameter int unsigned AW      = 6,
   parameter int unsigned MW      = 8,
   parameter int unsigned MIN_M   = 2,
   parameter int unsigned A_INIT  = 0,
   parameter int unsigned M_INIT  = 16,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned DW     = width_max(AW, MW)
) (
   input  logic          psc_clk,
   input  logic          rst,
   input  logic          cfg_we,
   input  logic          cfg_sel,
   input  logic [DW-1:0] cfg_data,
   output logic          mod32_o,
   output logic          cmp_pulse_o
);
   generate
      if (MIN_M < 2) begin : g_bad_min
         $error("MIN_M must be at least 2 for a one-clock pulse");
      end
      if (MIN_M > (1 << MW) - 1) begin : g_bad_range
         $error("MIN_M does not fit in MW bits");
      end
      if ((M_INIT > (1 << MW) - 1) || (A_INIT > (1 << AW) - 1)) begin : g_bad_init
         $error("initial settings exceed field widths");
      end
   endgenerate

   logic [AW-1:0] a_eff;
   logic [MW-1:0] m_eff;
   logic          boundary;

   div_cfg #(
      .AW(AW), .MW(MW), .DW(DW), .MIN_M(MIN_M),
      .A_INIT(A_INIT), .M_INIT(M_INIT)
   ) u_cfg (
      .clk   (psc_clk),
      .rst   (rst),
      .we    (cfg_we),
      .sel   (cfg_sel_e'(cfg_sel)),
      .data  (cfg_data),
      .a_eff (a_eff),
      .m_eff (m_eff)
   );

   div_main_ctr #(.MW(MW), .REG_OUT(OUT_REG)) u_main (
      .clk      (psc_clk),
      .rst      (rst),
      .load_val (m_eff),
      .last     (boundary),
      .pulse    (cmp_pulse_o)
   );

   div_swallow_ctr #(.AW(AW), .REG_OUT(OUT_REG)) u_swallow (
      .clk      (psc_clk),
      .rst      (rst),
      .load     (boundary),
      .load_val (a_eff),
      .mod32    (mod32_o)
   );

endmodule

// File: rtl/div_chk.sv
module div_chk (
   input logic clk,
   input logic rst,
   input logic mod32,
   input logic pulse
);
   // R1
   reset_out_chk: assert property (@(posedge clk)
      rst |=> (!pulse && mod32));

   // R2
   single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      pulse |=> !pulse);

   // R3
   mod_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (mod32 && !pulse && !$past(rst)) |=> mod32);

   // R7
   pulse_in32_chk: assert property (@(posedge clk) disable iff (rst)
      pulse |-> mod32);

endmodule

bind pswallow_div div_chk u_chk (
   .clk   (psc_clk),
   .rst   (rst),
   .mod32 (mod32_o),
   .pulse (cmp_pulse_o)
);

// File: tb/tb_pswallow_div.sv
module tb_pswallow_div;
   localparam int AW = 4;
   localparam int MW = 5;
   localparam int DW = 5;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          we  = 1'b0;
   logic          sel = 1'b0;
   logic [DW-1:0] wd  = '0;
   logic          mod32, pulse;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   pswallow_div #(
      .AW(AW), .MW(MW), .MIN_M(2), .A_INIT(3), .M_INIT(7), .OUT_REG(1'b1)
   ) dut (
      .psc_clk     (clk),
      .rst         (rst),
      .cfg_we      (we),
      .cfg_sel     (sel),
      .cfg_data    (wd),
      .mod32_o     (mod32),
      .cmp_pulse_o (pulse)
   );

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // observe one whole division cycle; optionally write during clock wr_k
   task automatic run_cycle(input int m, input int a, input int wr_k,
                            input bit wr_s, input int wr_d, input string req);
      for (int k = 0; k < m; k++) begin
         tick();
         chk(mod32 == (k >= a), req, $sformatf("mod32 clk %0d of M=%0d A=%0d", k, m, a),
             int'(mod32), int'(k >= a));
         chk(pulse == (k == m - 1), req, $sformatf("pulse clk %0d of M=%0d", k, m),
             int'(pulse), int'(k == m - 1));
         if (k == wr_k) begin
            we  = 1'b1;
            sel = wr_s;
            wd  = DW'(wr_d);
         end else begin
            we = 1'b0;
         end
      end
   endtask

   task automatic t_reset;
      rst = 1'b1;
      for (int i = 0; i < 3; i++) begin
         tick();
         chk(pulse == 1'b0, "R1", "pulse in reset", int'(pulse), 0);
         chk(mod32 == 1'b1, "R1", "mod32 in reset", int'(mod32), 1);
      end
      rst = 1'b0;
      run_cycle(7, 3, -1, 1'b0, 0, "R1");
      run_cycle(7, 3, -1, 1'b0, 0, "R2");
   endtask

   task automatic t_write_main;
      run_cycle(7, 3, 2, 1'b1, 10, "R5");     // M=10 written mid-cycle
      run_cycle(10, 3, -1, 1'b0, 0, "R4");
   endtask

   task automatic t_boundary_write;
      run_cycle(10, 3, 9, 1'b0, 9, "R5");     // A=9 captured on final edge
      run_cycle(10, 3, -1, 1'b0, 0, "R5");    // still old A
      run_cycle(10, 9, 0, 1'b0, 0, "R3");     // write A=0
   endtask

   task automatic t_swallow_zero;
      run_cycle(10, 0, 0, 1'b1, 0, "R3");     // write M=0
   endtask

   task automatic t_clamp_m;
      run_cycle(2, 0, 0, 1'b1, 1, "R6");      // M=0 clamped to 2; write M=1
      run_cycle(2, 0, 0, 1'b0, 5, "R6");      // M=1 clamped to 2; write A=5
   endtask

   task automatic t_clamp_a;
      run_cycle(2, 1, 0, 1'b1, 31, "R7");     // A=5 with M=2 -> 1; write M=31
      run_cycle(31, 5, 0, 1'b0, 15, "R2");    // full-scale M; write A=15
      run_cycle(31, 15, 0, 1'b1, 15, "R3");   // largest A; write M=15
      run_cycle(15, 14, 0, 1'b0, 22, "R7");   // A=15 with M=15 -> 14; write 5'b10110
   endtask

   task automatic t_wide_data;
      run_cycle(15, 6, -1, 1'b0, 0, "R4");    // only low 4 bits reach A
   endtask

   task automatic t_mid_reset;
      tick();
      tick();
      rst = 1'b1;
      for (int i = 0; i < 2; i++) begin
         tick();
         chk(pulse == 1'b0, "R1", "pulse in mid-cycle reset", int'(pulse), 0);
         chk(mod32 == 1'b1, "R1", "mod32 in mid-cycle reset", int'(mod32), 1);
      end
      rst = 1'b0;
      run_cycle(7, 3, -1, 1'b0, 0, "R1");
      run_cycle(7, 3, -1, 1'b0, 0, "R1");
   endtask

   initial begin
      #1;
      t_reset();
      t_write_main();
      t_boundary_write();
      t_swallow_zero();
      t_clamp_m();
      t_clamp_a();
      t_wide_data();
      t_mid_reset();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule